// File: doc/BRIEF.md
# Registered Add/Subtract Unit with Range Classification

This block adds or subtracts two small two's complement operands and sorts every result into one of three classes. The result either fits the signed range, or its true value is above the largest representable number (overflow), or it is below the smallest (underflow). A single mode input picks the operation. Subtraction reuses the same adder. The second operand is inverted bit by bit and the carry into the least significant stage is forced high.

The adder is a ripple of full-adder cells. The carry entering the most significant cell is brought out next to the final carry. The two carries disagree exactly when the signed result does not fit. When they disagree, the sign of the effective second operand tells which way the result went out of range. The operands share that sign whenever the flag fires. All outputs are registered, so a result appears one clock after its operands are sampled.

Top module: `addsub_classify`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is `sum_q`=0, `carry_q`=0, `ok_q`=1, `ovf_q`=0, `unf_q`=0, whatever the operand inputs are.
- R2: With `sub_mode`=0 sampled at a rising edge, `sum_q` after that edge equals (`op_a` + `op_b`) modulo 2^WIDTH.
- R3: With `sub_mode`=1 sampled at a rising edge, `sum_q` after that edge equals (`op_a` − `op_b`) modulo 2^WIDTH. For example, D − F gives E.
- R4: `carry_q` is bit WIDTH of the raw sum `op_a` + (`op_b` XOR all-`sub_mode`) + `sub_mode`. For example, F − F gives a carry of 1.
- R5: `ovf_q` is 1 exactly when the true signed result (operands read as −8..7 at WIDTH=4) is above the largest representable value. Examples: 6 + 4 and 7 − A.
- R6: `unf_q` is 1 exactly when the true signed result is below the smallest representable value. Examples: 8 + F, 8 − 1 and D − 7.
- R7: `ok_q` is 1 exactly when the true signed result is representable, including the wrapping cases D + 4, 7 + A, F + F, F − F and 6 − 4.
- R8: In every cycle exactly one of `ok_q`, `ovf_q`, `unf_q` is 1.
- R9: Outputs change only at a rising clock edge. Input changes between edges have no effect on the outputs until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | WIDTH | First operand, two's complement |
| op_b | input | WIDTH | Second operand, two's complement |
| sub_mode | input | 1 | 0 = add, 1 = subtract |
| sum_q | output | WIDTH | Registered result bits |
| carry_q | output | 1 | Registered raw carry out of the top cell |
| ok_q | output | 1 | Result fits the signed range |
| ovf_q | output | 1 | True result above the positive limit |
| unf_q | output | 1 | True result below the negative limit |

## Verification
The wrapped result bits and the range class come out of the same adder pass and are registered in the same cycle. A wrong flag is therefore visible only when it is read next to the sum it describes. The bench applies all 512 operand and mode combinations, one per clock. In each cycle it judges sum, carry and class together against signed integer arithmetic carried in a queue. It also provokes a synchronous reset while nonzero operands are present, to confirm that reset wins over a pending result.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  typedef enum logic [1:0] {
    RC_FITS  = 2'd0,
    RC_ABOVE = 2'd1,
    RC_BELOW = 2'd2
  } range_class_e;
endpackage

// File: rtl/fa_cell.sv
module fa_cell (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  assign s  = x ^ y ^ ci;
  assign co = (x & y) | (ci & (x ^ y));
endmodule

// File: rtl/operand_conditioner.sv
module operand_conditioner #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] b_in,
  input  logic             sub,
  output logic [WIDTH-1:0] b_eff,
  output logic             cin
);
  assign b_eff = b_in ^ {WIDTH{sub}};
  assign cin   = sub;
endmodule

// File: rtl/ripple_chain.sv
module ripple_chain #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             cin,
  output logic [WIDTH-1:0] s,
  output logic             c_top_in,
  output logic             c_out
);
  logic [WIDTH:0] c;
  assign c[0] = cin;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    fa_cell u_fa (
      .x  (x[i]),
      .y  (y[i]),
      .ci (c[i]),
      .s  (s[i]),
      .co (c[i+1])
    );
  end

  assign c_top_in = c[WIDTH-1];
  assign c_out    = c[WIDTH];
endmodule

// File: rtl/range_classifier.sv
module range_classifier
  import addsub_pkg::*;
(
  input  logic         c_top_in,
  input  logic         c_out,
  input  logic         b_eff_sign,
  output range_class_e cls
);
  logic out_of_range;
  assign out_of_range = c_top_in ^ c_out;

  always_comb begin
    if (!out_of_range)   cls = RC_FITS;
    else if (b_eff_sign) cls = RC_BELOW;
    else                 cls = RC_ABOVE;
  end
endmodule

// File: rtl/addsub_classify.sv
module addsub_classify
  import addsub_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             sub_mode,
  output logic [WIDTH-1:0] sum_q,
  output logic             carry_q,
  output logic             ok_q,
  output logic             ovf_q,
  output logic             unf_q
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic             cin;
  logic [WIDTH-1:0] sum_d;
  logic             c_top_in;
  logic             c_out;
  range_class_e     cls;

  operand_conditioner #(.WIDTH(WIDTH)) u_cond (
    .b_in  (op_b),
    .sub   (sub_mode),
    .b_eff (b_eff),
    .cin   (cin)
  );

  ripple_chain #(.WIDTH(WIDTH)) u_chain (
    .x        (op_a),
    .y        (b_eff),
    .cin      (cin),
    .s        (sum_d),
    .c_top_in (c_top_in),
    .c_out    (c_out)
  );

  range_classifier u_cls (
    .c_top_in   (c_top_in),
    .c_out      (c_out),
    .b_eff_sign (b_eff[MSB]),
    .cls        (cls)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q   <= '0;
      carry_q <= 1'b0;
      ok_q    <= 1'b1;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
    end else begin
      sum_q   <= sum_d;
      carry_q <= c_out;
      ok_q    <= (cls == RC_FITS);
      ovf_q   <= (cls == RC_ABOVE);
      unf_q   <= (cls == RC_BELOW);
    end
  end
endmodule

// File: rtl/addsub_classify_chk.sv
module addsub_classify_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             sub_mode,
  input logic [WIDTH-1:0] sum_q,
  input logic             carry_q,
  input logic             ok_q,
  input logic             ovf_q,
  input logic             unf_q
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] add_ref;
  logic [WIDTH-1:0] sub_ref;
  assign add_ref = op_a + op_b;
  assign sub_ref = op_a - op_b;

  // R1
  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (sum_q == '0 && !carry_q && ok_q && !ovf_q && !unf_q));

  // R2
  p_add_sum_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(sub_mode)) |-> (sum_q == $past(add_ref)));

  // R3
  p_sub_sum_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sub_mode)) |-> (sum_q == $past(sub_ref)));

  // R5: positive overflow wraps to a negative pattern from a non-negative first operand
  p_ovf_shape_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ovf_q) |-> (sum_q[MSB] && !$past(op_a[MSB])));

  // R6: negative underflow wraps to a non-negative pattern from a negative first operand
  p_unf_shape_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && unf_q) |-> (!sum_q[MSB] && $past(op_a[MSB])));

  // R8
  p_one_class_r8: assert property (@(posedge clk) disable iff (rst)
    $countones({ok_q, ovf_q, unf_q}) == 1);
endmodule

bind addsub_classify addsub_classify_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .op_a     (op_a),
  .op_b     (op_b),
  .sub_mode (sub_mode),
  .sum_q    (sum_q),
  .carry_q  (carry_q),
  .ok_q     (ok_q),
  .ovf_q    (ovf_q),
  .unf_q    (unf_q)
);

// File: tb/tb_addsub_classify.sv
module tb_addsub_classify;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] op_a, op_b;
  logic         sub_mode;
  logic [W-1:0] sum_q;
  logic         carry_q, ok_q, ovf_q, unf_q;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  typedef struct {
    int sum;
    int carry;
    int cls;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  addsub_classify #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .sub_mode(sub_mode),
    .sum_q(sum_q), .carry_q(carry_q), .ok_q(ok_q), .ovf_q(ovf_q), .unf_q(unf_q)
  );

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // class code: 0 fits, 1 above, 2 below; flags read as {ok,ovf,unf}
  function automatic exp_t model(int a, int b, int s);
    exp_t e;
    int sa = (a > 7) ? a - 16 : a;
    int sb = (b > 7) ? b - 16 : b;
    int t  = s ? sa - sb : sa + sb;
    int be = s ? (~b & 15) : b;
    e.sum   = t & 15;
    e.carry = ((a + be + s) >> 4) & 1;
    e.cls   = (t > 7) ? 1 : (t < -8) ? 2 : 0;
    return e;
  endfunction

  task automatic judge();
    exp_t e;
    int flags, want;
    e = q.pop_front();
    check(sub_mode_prev ? "R3 sum" : "R2 sum", int'(sum_q), e.sum);
    check("R4 carry", int'(carry_q), e.carry);
    flags = {29'd0, ok_q, ovf_q, unf_q};
    want  = (e.cls == 1) ? 3'b010 : (e.cls == 2) ? 3'b001 : 3'b100;
    if (e.cls == 1)      check("R5 class", flags, want);
    else if (e.cls == 2) check("R6 class", flags, want);
    else                 check("R7 class", flags, want);
    check("R8 onehot", $countones({ok_q, ovf_q, unf_q}), 1);
  endtask

  bit sub_mode_prev;

  task automatic apply(int a, int b, int s);
    int held;
    @(negedge clk);
    if (q.size() > 0) judge();
    held = {27'd0, sum_q, ok_q};
    op_a = W'(a); op_b = W'(b); sub_mode = s[0];
    sub_mode_prev = s[0];
    #1;
    check("R9 hold", {27'd0, sum_q, ok_q}, held);
    q.push_back(model(a, b, s));
  endtask

  task automatic check_reset();
    check("R1 sum", int'(sum_q), 0);
    check("R1 carry", int'(carry_q), 0);
    check("R1 flags", {29'd0, ok_q, ovf_q, unf_q}, 3'b100);
  endtask

  initial begin
    rst = 1'b1; op_a = '0; op_b = '0; sub_mode = 1'b0;
    repeat (2) @(negedge clk);
    check_reset();
    rst = 1'b0;

    // directed examples: D+F, D-F, 6+4, 7-A, 8+F, 8-1, D-7, D+4, 7+A, F+F, F-F, 6-4
    apply(13, 15, 0); apply(13, 15, 1); apply(6, 4, 0);  apply(7, 10, 1);
    apply(8, 15, 0);  apply(8, 1, 1);   apply(13, 7, 1); apply(13, 4, 0);
    apply(7, 10, 0);  apply(15, 15, 0); apply(15, 15, 1); apply(6, 4, 1);

    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          apply(a, b, s);
    @(negedge clk);
    judge();

    // R1: reset overrides nonzero pending operands
    op_a = 4'h7; op_b = 4'h6; sub_mode = 1'b0; rst = 1'b1;
    @(negedge clk);
    check_reset();
    rst = 1'b0;

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule